// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers 64 level-type status inputs, arranged as eight registers of eight bits. It turns each qualifying change of an input into a sticky interrupt-status bit. An input is qualifying if it passes a per-bit edge classification that is fixed at build time: rising-only, or both edges. A processor reads a status register over a single-cycle register port. That read returns the latched bits and empties the register in the same cycle. When a dual-edge bit is set, software inspects the live input to learn which edge occurred.

Each register has a writable per-bit enable. An event on an enabled bit also sets a request bit. The request bits of one register are ORed into one master-summary bit, and any master-summary bit drives the active-low interrupt output low. An event on a disabled bit still latches in the status register. It does not raise a request, a master bit or the interrupt output.

Top module: `irq_status_agg`

## Requirements
- R1: A latched status bit stays set through any number of cycles and through the source returning to its idle level, until its register is read.
- R2: A read of a status register returns the latched bits on `bus_rdata` in the cycle after the read. In the same cycle it clears every status bit and every request bit of that register. Other registers are left untouched.
- R3: A rising-edge bit, which is any bit whose `DUAL_MASK` bit is 0, latches only on a 0-to-1 change of its source. A 1-to-0 change latches nothing.
- R4: A dual-edge bit latches on both the 0-to-1 and the 1-to-0 change of its source. Bit b of register k is source bit 8k+b. The default `DUAL_MASK` is 64'h8000_0000_0000_0081, which makes bits 0, 7 and 63 dual-edge.
- R5: Register k's enable lives at address 0x013-k, and reads of that address return it. An event on an enabled bit sets `req_vec[8k+b]`.
- R6: `mst_sum[k]` is high exactly when register k has any request bit set. `irq_n` is low exactly when any `mst_sum` bit is high.
- R7: An event on a disabled bit latches in status but sets no request bit, no master bit and does not pull `irq_n` low.
- R8: Status register k is read at address 0x00B-k, which places register 7 at 0x004 and register 0 at 0x00B.
- R9: An event that lands in the same cycle as the clearing read of its register leaves its bit set.
- R10: After reset, all status bits, enables and request bits are 0, `mst_sum` is 0, `irq_n` is 1 and `bus_rdata` is 0.
- R11: A source change applied before a clock edge is latched by the third rising edge. A read issued after that edge returns the bit.
- R12: Writes to status addresses have no effect. Reads of unmapped addresses return 0 and clear nothing.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Asynchronous status sources, bit 8k+b = register k bit b |
| bus_addr | input | 12 | Register address |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd`, else 0 |
| req_vec | output | 64 | Latched-and-enabled request bits |
| mst_sum | output | 8 | Master summary, one bit per register |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The hardest case to reach is a new event arriving in exactly the same clock edge as the read that clears its register. The source passes through two synchronizer flops and a previous-value flop, so the bench changes the source on a falling edge, lets two rising edges pass, and then issues the read so that it is sampled on the edge where the event is raised. A second bit, latched earlier, shows that the read returned and cleared the old contents while the coincident event survived into the next read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Address of slot k in a descending block whose top address is top_addr.
  function automatic logic [31:0] slot_addr(input int unsigned top_addr,
                                            input int unsigned k);
    return 32'(top_addr - k);
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned   W         = 64,
  parameter logic [W-1:0]  DUAL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] evt_o
);

  localparam logic [W-1:0] RISE_MASK = ~DUAL_MASK;

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (DUAL_MASK[i]) begin : g_dual
      assign evt_o[i] = sync_q[i] ^ prev_q[i];
    end else begin : g_rise
      assign evt_o[i] = sync_q[i] & ~prev_q[i];
    end
  end

  // A rising-only event must be followed by a high previous value.
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((evt_o & RISE_MASK) != '0) |=> ((($past(evt_o) & RISE_MASK) & ~prev_q) == '0)); // R3

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] req_o
);

  logic [W-1:0] stat_q;
  logic [W-1:0] en_q;
  logic [W-1:0] req_q;
  logic [W-1:0] keep;

  assign keep = clr_i ? '0 : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      req_q  <= '0;
    end else begin
      stat_q <= evt_i | (stat_q & keep);
      req_q  <= (evt_i & en_q) | (req_q & keep);
      if (en_wr_i) begin
        en_q <= en_wdata_i;
      end
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign req_o  = req_q;

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R1

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_i == '0) |=> (stat_q == '0 && req_q == '0)); // R2

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((evt_i & ~en_q & ~req_q) != '0) |=> ((req_q & $past(evt_i & ~en_q & ~req_q)) == '0)); // R7

endmodule

// File: rtl/irq_bus_dec.sv
module irq_bus_dec #(
  parameter int unsigned NREG     = 8,
  parameter int unsigned W        = 8,
  parameter int unsigned AW       = 12,
  parameter int unsigned STAT_TOP = 11,
  parameter int unsigned EN_TOP   = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [NREG*W-1:0] stat_i,
  input  logic [NREG*W-1:0] en_i,
  output logic [NREG-1:0]   clr_o,
  output logic [NREG-1:0]   enwr_o,
  output logic [W-1:0]      rdata_o
);

  import irq_agg_pkg::*;

  logic [NREG-1:0] hit_stat;
  logic [NREG-1:0] hit_en;
  logic [W-1:0]    rd_mux;
  logic [W-1:0]    rdata_q;

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    localparam logic [AW-1:0] STAT_A = AW'(slot_addr(STAT_TOP, k));
    localparam logic [AW-1:0] EN_A   = AW'(slot_addr(EN_TOP, k));
    assign hit_stat[k] = (addr_i == STAT_A);
    assign hit_en[k]   = (addr_i == EN_A);
    assign clr_o[k]    = rd_i & hit_stat[k];
    assign enwr_o[k]   = wr_i & hit_en[k];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NREG; k++) begin
      if (hit_stat[k]) rd_mux = rd_mux | stat_i[k*W +: W];
      if (hit_en[k])   rd_mux = rd_mux | en_i[k*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign rdata_o = rdata_q;

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_o)); // R8

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_q == '0)); // R12

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int unsigned             NREG      = 8,
  parameter int unsigned             W         = 8,
  parameter int unsigned             AW        = 12,
  parameter int unsigned             STAT_TOP  = 11,
  parameter int unsigned             EN_TOP    = 19,
  parameter logic [NREG*W-1:0]       DUAL_MASK = 64'h8000_0000_0000_0081
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG*W-1:0] src_i,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic [NREG*W-1:0] req_vec,
  output logic [NREG-1:0]   mst_sum,
  output logic              irq_n
);

  localparam int unsigned NB = NREG * W;

  logic [NB-1:0]   evt;
  logic [NB-1:0]   stat_all;
  logic [NB-1:0]   en_all;
  logic [NB-1:0]   req_all;
  logic [NREG-1:0] clr;
  logic [NREG-1:0] enwr;
  logic [NREG-1:0] mst_q;
  logic            irq_n_q;

  irq_edge_det #(.W(NB), .DUAL_MASK(DUAL_MASK)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .src_i(src_i),
    .evt_o(evt)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_bank
    irq_reg_bank #(.W(W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (evt[k*W +: W]),
      .clr_i     (clr[k]),
      .en_wr_i   (enwr[k]),
      .en_wdata_i(bus_wdata),
      .stat_o    (stat_all[k*W +: W]),
      .en_o      (en_all[k*W +: W]),
      .req_o     (req_all[k*W +: W])
    );
  end

  irq_bus_dec #(
    .NREG(NREG), .W(W), .AW(AW), .STAT_TOP(STAT_TOP), .EN_TOP(EN_TOP)
  ) u_bus (
    .clk    (clk),
    .rst    (rst),
    .addr_i (bus_addr),
    .rd_i   (bus_rd),
    .wr_i   (bus_wr),
    .stat_i (stat_all),
    .en_i   (en_all),
    .clr_o  (clr),
    .enwr_o (enwr),
    .rdata_o(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      for (int k = 0; k < NREG; k++) begin
        mst_q[k] <= |req_all[k*W +: W];
      end
      irq_n_q <= ~|req_all;
    end
  end

  assign req_vec = req_all;
  assign mst_sum = mst_q;
  assign irq_n   = irq_n_q;

  AST_IRQ_SUM: assert property (@(posedge clk) disable iff (rst)
    irq_n_q == (mst_q == '0)); // R6

  AST_REQ_IN_STAT: assert property (@(posedge clk) disable iff (rst)
    (req_all & ~stat_all) == '0); // R5

endmodule

// File: tb/sim_irq_status_agg.sv
`timescale 1ns/1ps
module sim_irq_status_agg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] req_vec;
  logic [7:0]  mst_sum;
  logic        irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_status_agg u0 (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .req_vec(req_vec), .mst_sum(mst_sum), .irq_n(irq_n)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = v;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_src(input int b, input logic v);
    @(negedge clk);
    src_i[b] = v;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk({63'b0, irq_n}, 64'h1, "R10 irq_n");
    chk({56'b0, mst_sum}, 64'h0, "R10 mst_sum");
    chk(req_vec, 64'h0, "R10 req_vec");
    chk({56'b0, bus_rdata}, 64'h0, "R10 rdata");
    do_read(12'h00B, d); chk({56'b0, d}, 64'h0, "R10 status reg0");
    do_read(12'h010, d); chk({56'b0, d}, 64'h0, "R10 enable reg3");
  endtask

  task automatic t_rising();
    logic [7:0] d;
    set_src(1, 1'b1);
    repeat (3) @(posedge clk);
    do_read(12'h00B, d); chk({56'b0, d}, 64'h02, "R11 latency / R3 rise");
    do_read(12'h00B, d); chk({56'b0, d}, 64'h00, "R2 cleared");
    set_src(1, 1'b0); settle();
    do_read(12'h00B, d); chk({56'b0, d}, 64'h00, "R3 fall ignored");
  endtask

  task automatic t_dual();
    logic [7:0] d;
    set_src(0, 1'b1); settle();
    do_read(12'h00B, d); chk({56'b0, d}, 64'h01, "R4 dual rise");
    set_src(0, 1'b0); settle();
    do_read(12'h00B, d); chk({56'b0, d}, 64'h01, "R4 dual fall");
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    set_src(43, 1'b1);
    repeat (20) @(posedge clk);
    set_src(43, 1'b0); settle();
    do_read(12'h007, d); chk({56'b0, d}, 64'h00, "R8 reg4 untouched");
    do_read(12'h006, d); chk({56'b0, d}, 64'h08, "R1 sticky reg5");
    do_read(12'h006, d); chk({56'b0, d}, 64'h00, "R2 reg5 cleared");
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    set_src(20, 1'b1); settle();
    chk(req_vec, 64'h0, "R7 no request");
    chk({56'b0, mst_sum}, 64'h0, "R7 no master");
    chk({63'b0, irq_n}, 64'h1, "R7 irq_n high");
    do_read(12'h009, d); chk({56'b0, d}, 64'h10, "R7 status latched");
    set_src(20, 1'b0); settle();
  endtask

  task automatic t_enabled();
    logic [7:0] d;
    do_write(12'h00D, 8'h21);
    do_read(12'h00D, d); chk({56'b0, d}, 64'h21, "R5 enable readback");
    set_src(53, 1'b1); settle();
    chk(req_vec, 64'h0020_0000_0000_0000, "R5 request bit");
    chk({56'b0, mst_sum}, 64'h40, "R6 master reg6");
    chk({63'b0, irq_n}, 64'h0, "R6 irq_n low");
    do_read(12'h005, d); chk({56'b0, d}, 64'h20, "R8 reg6 status");
    settle();
    chk(req_vec, 64'h0, "R2 request cleared");
    chk({56'b0, mst_sum}, 64'h0, "R6 master cleared");
    chk({63'b0, irq_n}, 64'h1, "R6 irq_n released");
    set_src(53, 1'b0); settle();
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    set_src(17, 1'b1); settle();
    set_src(18, 1'b1);
    repeat (2) @(posedge clk);
    do_read(12'h009, d); chk({56'b0, d}, 64'h02, "R9 old contents");
    do_read(12'h009, d); chk({56'b0, d}, 64'h04, "R9 event kept");
    set_src(17, 1'b0); set_src(18, 1'b0); settle();
  endtask

  task automatic t_bus_misc();
    logic [7:0] d;
    set_src(9, 1'b1); settle();
    do_write(12'h00A, 8'hFF);
    do_read(12'h020, d); chk({56'b0, d}, 64'h00, "R12 unmapped zero");
    do_read(12'h00A, d); chk({56'b0, d}, 64'h02, "R12 write ignored");
    set_src(9, 1'b0); settle();
  endtask

  task automatic t_dual_fall_irq();
    logic [7:0] d;
    do_write(12'h00C, 8'h80);
    set_src(63, 1'b1); settle();
    do_read(12'h004, d); chk({56'b0, d}, 64'h80, "R4 reg7 rise");
    settle();
    set_src(63, 1'b0); settle();
    chk(req_vec, 64'h8000_0000_0000_0000, "R4 fall request");
    chk({56'b0, mst_sum}, 64'h80, "R6 master reg7");
    chk({63'b0, irq_n}, 64'h0, "R6 irq_n on fall");
    do_read(12'h004, d); chk({56'b0, d}, 64'h80, "R4 fall latched");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rising();
    t_dual();
    t_sticky();
    t_disabled();
    t_enabled();
    t_same_cycle();
    t_bus_misc();
    t_dual_fall_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule